// File: doc/BRIEF.md
# SPI Chip-Select and Serial-Clock Timing Controller

This block sits between a transfer sequencer and the pins of an SPI flash interface. It owns the chip-select lines and the resting level of the serial clock. Its timing comes from four programmable delays, each counted in reference-clock cycles: the setup time before the first clock edge, the hold time after the last edge, the minimum deselect time between transfers, and an extra gap that is added only when consecutive transfers address different devices. A sequencer raises a request. The block selects the device, waits out the setup delay and then grants the transfer. While the grant is high, the sequencer paces the serial clock with single-cycle ticks. The sequencer ends the transfer with an end pulse. The block then keeps the device selected for the hold time and afterwards enforces the deselect time.

The chip-select output has two forms. In the one-hot form, only the line of the chosen device is driven low. In the encoded form, the 4-bit device number is passed straight out to an external decoder. Clock polarity sets the resting level of the clock. Clock phase chooses which clock transition produces the capture strobe for the data path. Data shifting and baud-rate division are handled elsewhere.

Top module: `spi_cs_timing_ctrl`

## Requirements
- R1: After a synchronous reset: `cs_n` = 4'b1111, `xfer_grant` = 0, `bus_idle` = 1, `capture` = 0, and `sclk` equals `cfg_cpol`.
- R2: With `cfg_dec` = 0 and device n (0..3) selected, `cs_n` is all ones except bit n, which is 0.
- R3: With `cfg_dec` = 1, `cs_n` carries the selected device number unchanged while the device is selected. In both forms the deselected value is 4'b1111.
- R4: The device is selected for exactly max(`tm_setup`,1) cycles with `xfer_grant` low before `xfer_grant` rises.
- R5: After `xfer_end` is sampled high while granted, `xfer_grant` falls in the same cycle and the device stays selected for exactly max(`tm_hold`,1) cycles.
- R6: Between two transfers to the same device, with a request waiting, chip select stays deasserted for exactly max(`tm_gap`,1) cycles.
- R7: When the next transfer targets a different device than the previous one, the deasserted time is max(`tm_gap`,1)+max(`tm_switch`,1) cycles.
- R8: The device number and the output form are captured when a request is accepted. Changing `cfg_sel` or `cfg_dec` during a transfer does not change `cs_n`.
- R9: `bus_idle` is 1 only when no transfer is in progress and chip select is deasserted. It is 0 from acceptance of a request until the deselect time has elapsed.
- R10: Outside the granted phase, `sclk` rests at `cfg_cpol` and ignores `sclk_tick`. While granted, each `sclk_tick` toggles `sclk` once.
- R11: `capture` pulses on the toggle that leaves the resting level when `cfg_cpha` = 0, and on the toggle that returns to it when `cfg_cpha` = 1. It is never high outside the granted phase.
- R12: While `cfg_en` = 0, no new request is accepted: the block stays idle with chip select deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Allows new requests to be accepted |
| cfg_cpol | input | 1 | Resting level of the serial clock |
| cfg_cpha | input | 1 | 0: capture on leading toggle, 1: on trailing toggle |
| cfg_dec | input | 1 | 1: encoded chip-select for an external decoder |
| cfg_sel | input | 4 | Target device number |
| tm_setup | input | 8 | Select-to-grant delay in cycles |
| tm_hold | input | 8 | End-to-deselect delay in cycles |
| tm_switch | input | 8 | Extra deselect cycles when the device changes |
| tm_gap | input | 8 | Minimum deselect cycles between transfers |
| xfer_req | input | 1 | Transfer request from the sequencer |
| xfer_end | input | 1 | Last clock edge has been issued |
| sclk_tick | input | 1 | Toggle request for the serial clock |
| xfer_grant | output | 1 | Transfer may clock |
| bus_idle | output | 1 | No transfer active, chip select deasserted |
| cs_n | output | 4 | Chip-select lines (one-hot low or encoded) |
| sclk | output | 1 | Serial clock |
| capture | output | 1 | One-cycle capture strobe for the data path |

## Verification
The assertions check every cycle that `bus_idle` implies deselected lines and no grant, that chip select is active on the cycle before a grant rises and on the cycle after it falls, that `cs_n` does not move while granted, that the capture strobe appears only inside a grant, and that a disabled controller stays idle. The exact lengths of the setup, hold, deselect and device-switch intervals, the edge that the zero-delay setting yields, the one-hot and encoded patterns, and the polarity and phase of the strobe can only be shown by the bench's scenarios. The bench measures those intervals cycle by cycle.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_SETUP,
    ST_ACTIVE,
    ST_HOLD,
    ST_GAP
  } cst_state_e;
endpackage

// File: rtl/cst_delay_cnt.sv
// Counts cycles spent in the current phase; a programmed 0 behaves as 1.
module cst_delay_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DLY_W-1:0] dly,
  output logic             expired
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] last_idx;

  assign last_idx = (dly == '0) ? '0 : dly - DLY_W'(1);
  assign expired  = (cnt_q >= last_idx);

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + DLY_W'(1);
  end
endmodule

// File: rtl/cst_cs_drive.sv
// Registered chip-select encoder: one-hot active-low or pass-through code.
module cst_cs_drive #(
  parameter int CS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_on,
  input  logic            enc_mode,
  input  logic [CS_W-1:0] dev,
  output logic [CS_W-1:0] cs_n
);
  logic [CS_W-1:0] cs_nxt;

  always_comb begin
    cs_nxt = '1;
    if (sel_on) begin
      if (enc_mode) cs_nxt = dev;
      else begin
        for (int i = 0; i < CS_W; i++)
          if (dev == CS_W'(i)) cs_nxt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cs_n <= '1;
    else     cs_n <= cs_nxt;
  end
endmodule

// File: rtl/cst_sclk_gen.sv
// Serial clock level keeper and capture-strobe generator.
module cst_sclk_gen (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic cpha,
  input  logic run,
  input  logic tick,
  output logic sclk,
  output logic capture
);
  logic lead;
  assign lead = (~sclk) != cpol;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk    <= cpol;
      capture <= 1'b0;
    end else if (run && tick) begin
      sclk    <= ~sclk;
      capture <= lead ^ cpha;
    end else begin
      capture <= 1'b0;
      if (!run) sclk <= cpol;
    end
  end
endmodule

// File: rtl/spi_cs_timing_ctrl.sv
module spi_cs_timing_ctrl
  import cst_pkg::*;
#(
  parameter int CS_W  = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_dec,
  input  logic [CS_W-1:0]  cfg_sel,
  input  logic [DLY_W-1:0] tm_setup,
  input  logic [DLY_W-1:0] tm_hold,
  input  logic [DLY_W-1:0] tm_switch,
  input  logic [DLY_W-1:0] tm_gap,
  input  logic             xfer_req,
  input  logic             xfer_end,
  input  logic             sclk_tick,
  output logic             xfer_grant,
  output logic             bus_idle,
  output logic [CS_W-1:0]  cs_n,
  output logic             sclk,
  output logic             capture
);
  cst_state_e       st_q, st_n, st_first;
  logic [CS_W-1:0]  tgt_q, last_q, dev_n;
  logic             dec_q, dec_n, last_vld_q, cs_act_q;
  logic             start_ok, take, expired, run, cs_on_n;
  logic [DLY_W-1:0] dly_cur;

  assign start_ok = xfer_req && cfg_en;
  assign st_first = (last_vld_q && (cfg_sel != last_q)) ? ST_SWITCH : ST_SETUP;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_ok) st_n = st_first;
      ST_SWITCH: if (expired)  st_n = ST_SETUP;
      ST_SETUP:  if (expired)  st_n = ST_ACTIVE;
      ST_ACTIVE: if (xfer_end) st_n = ST_HOLD;
      ST_HOLD:   if (expired)  st_n = ST_GAP;
      ST_GAP:    if (expired)  st_n = start_ok ? st_first : ST_IDLE;
      default:                 st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_SWITCH: dly_cur = tm_switch;
      ST_SETUP:  dly_cur = tm_setup;
      ST_HOLD:   dly_cur = tm_hold;
      ST_GAP:    dly_cur = tm_gap;
      default:   dly_cur = '0;
    endcase
  end

  assign take    = start_ok && ((st_q == ST_IDLE) || ((st_q == ST_GAP) && expired));
  assign dev_n   = take ? cfg_sel : tgt_q;
  assign dec_n   = take ? cfg_dec : dec_q;
  assign cs_on_n = (st_n == ST_SETUP) || (st_n == ST_ACTIVE) || (st_n == ST_HOLD);
  assign run     = (st_q == ST_ACTIVE) && (st_n == ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      tgt_q      <= '0;
      dec_q      <= 1'b0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
      xfer_grant <= 1'b0;
      bus_idle   <= 1'b1;
      cs_act_q   <= 1'b0;
    end else begin
      st_q       <= st_n;
      tgt_q      <= dev_n;
      dec_q      <= dec_n;
      xfer_grant <= (st_n == ST_ACTIVE);
      bus_idle   <= (st_n == ST_IDLE);
      cs_act_q   <= cs_on_n;
      if ((st_q == ST_ACTIVE) && (st_n == ST_HOLD)) begin
        last_q     <= tgt_q;
        last_vld_q <= 1'b1;
      end
    end
  end

  cst_delay_cnt #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .clr(st_n != st_q), .dly(dly_cur), .expired(expired)
  );

  cst_cs_drive #(.CS_W(CS_W)) u_cs (
    .clk(clk), .rst(rst), .sel_on(cs_on_n), .enc_mode(dec_n), .dev(dev_n), .cs_n(cs_n)
  );

  cst_sclk_gen u_sclk (
    .clk(clk), .rst(rst), .cpol(cfg_cpol), .cpha(cfg_cpha), .run(run),
    .tick(sclk_tick), .sclk(sclk), .capture(capture)
  );

  AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (rst) bus_idle |-> (cs_n == '1 && !cs_act_q)) else $error("idle with device selected"); // R9
  AST_GRANT_NOT_IDLE: assert property (@(posedge clk) disable iff (rst) xfer_grant |-> !bus_idle) else $error("grant while idle"); // R9
  AST_SETUP_BEFORE_GRANT: assert property (@(posedge clk) disable iff (rst) $rose(xfer_grant) |-> $past(cs_act_q)) else $error("grant without setup"); // R4
  AST_HOLD_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst) $fell(xfer_grant) |-> cs_act_q) else $error("no hold after grant"); // R5
  AST_CS_STABLE_GRANT: assert property (@(posedge clk) disable iff (rst) (xfer_grant && $past(xfer_grant)) |-> $stable(cs_n)) else $error("cs moved in transfer"); // R8
  AST_CAPTURE_IN_GRANT: assert property (@(posedge clk) disable iff (rst) capture |-> xfer_grant) else $error("strobe outside grant"); // R11
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst) (bus_idle && !cfg_en) |=> bus_idle) else $error("disabled block left idle"); // R12
endmodule

// File: tb/test_spi_cs_timing_ctrl.sv
module test_spi_cs_timing_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // fields: dev_a[41:38] dev_b[37:34] dec[33] cpol[32] setup[31:24] hold[23:16] gap[15:8] switch[7:0]
  localparam logic [41:0] VECS [NVEC] = '{
    {4'd0, 4'd0, 1'b0, 1'b0, 8'd3,  8'd2, 8'd4, 8'd5},
    {4'd1, 4'd2, 1'b0, 1'b1, 8'd1,  8'd1, 8'd1, 8'd1},
    {4'd3, 4'd0, 1'b0, 1'b0, 8'd0,  8'd0, 8'd0, 8'd0},
    {4'd5, 4'd9, 1'b1, 1'b1, 8'd2,  8'd3, 8'd2, 8'd6},
    {4'd9, 4'd9, 1'b1, 1'b0, 8'd10, 8'd7, 8'd0, 8'd200},
    {4'd2, 4'd3, 1'b0, 1'b0, 8'd20, 8'd4, 8'd3, 8'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_en = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_dec = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [7:0] tm_setup = 8'd1, tm_hold = 8'd1, tm_switch = 8'd1, tm_gap = 8'd1;
  logic xfer_req = 1'b0, xfer_end = 1'b0, sclk_tick = 1'b0;
  logic xfer_grant, bus_idle, sclk, capture;
  logic [3:0] cs_n;
  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cs_timing_ctrl i_spi_cs_timing_ctrl (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_dec(cfg_dec), .cfg_sel(cfg_sel), .tm_setup(tm_setup), .tm_hold(tm_hold),
    .tm_switch(tm_switch), .tm_gap(tm_gap), .xfer_req(xfer_req), .xfer_end(xfer_end),
    .sclk_tick(sclk_tick), .xfer_grant(xfer_grant), .bus_idle(bus_idle), .cs_n(cs_n),
    .sclk(sclk), .capture(capture)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int atl1(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic logic [3:0] cs_code(input logic dec, input logic [3:0] n);
    return dec ? n : ~(4'b0001 << n);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cs_n", cs_n, 4'hF);
    check("R1 grant", xfer_grant, 0);
    check("R1 idle", bus_idle, 1);
    check("R1 capture", capture, 0);
    check("R1 sclk", sclk, cfg_cpol);

    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v;
      int n_set, n_hold, n_gap, exp_gap;
      logic sel_seen;
      v = VECS[i];
      cfg_dec = v[33]; cfg_cpol = v[32];
      tm_setup = v[31:24]; tm_hold = v[23:16]; tm_gap = v[15:8]; tm_switch = v[7:0];
      cfg_sel = v[41:38];
      repeat (2) @(negedge clk);
      xfer_req = 1'b1;
      n_set = 0;
      sel_seen = 1'b0;
      @(negedge clk);
      while (!xfer_grant) begin
        if (cs_n != 4'hF) n_set++;
        @(negedge clk);
      end
      check($sformatf("R4 setup v%0d", i), n_set, atl1(v[31:24]));
      check($sformatf("R2/R3 cs a v%0d", i), cs_n, cs_code(v[33], v[41:38]));
      check($sformatf("R9 idle low v%0d", i), bus_idle, 0);
      check($sformatf("R10 sclk rest v%0d", i), sclk, v[32]);
      cfg_sel = v[37:34];
      cfg_dec = ~v[33];
      @(negedge clk);
      check($sformatf("R8 cs latched v%0d", i), cs_n, cs_code(v[33], v[41:38]));
      cfg_dec = v[33];
      xfer_end = 1'b1;
      n_hold = 0;
      @(negedge clk);
      xfer_end = 1'b0;
      check($sformatf("R5 grant drop v%0d", i), xfer_grant, 0);
      while (cs_n == cs_code(v[33], v[41:38])) begin
        n_hold++;
        @(negedge clk);
      end
      check($sformatf("R5/R8 hold v%0d", i), n_hold, atl1(v[23:16]));
      n_gap = 0;
      while (cs_n == 4'hF) begin
        n_gap++;
        if (bus_idle) sel_seen = 1'b1;
        @(negedge clk);
      end
      exp_gap = atl1(v[15:8]) + ((v[41:38] != v[37:34]) ? atl1(v[7:0]) : 0);
      check($sformatf("%s gap v%0d", (v[41:38] != v[37:34]) ? "R7" : "R6", i), n_gap, exp_gap);
      check($sformatf("R9 no idle in gap v%0d", i), sel_seen, 0);
      check($sformatf("R2/R3 cs b v%0d", i), cs_n, cs_code(v[33], v[37:34]));
      xfer_req = 1'b0;
      while (!xfer_grant) @(negedge clk);
      xfer_end = 1'b1;
      @(negedge clk);
      xfer_end = 1'b0;
      while (!bus_idle) @(negedge clk);
      check($sformatf("R3 deselect v%0d", i), cs_n, 4'hF);
    end

    // R12: disabled block ignores requests
    cfg_en = 1'b0; cfg_dec = 1'b0; cfg_sel = 4'd1; cfg_cpol = 1'b0;
    xfer_req = 1'b1;
    repeat (10) @(negedge clk);
    check("R12 idle kept", bus_idle, 1);
    check("R12 cs off", cs_n, 4'hF);
    check("R12 no grant", xfer_grant, 0);
    xfer_req = 1'b0;
    cfg_en = 1'b1;

    // R10/R11: clock toggling and strobe phase
    tm_setup = 8'd1; tm_hold = 8'd4; tm_gap = 8'd1; tm_switch = 8'd1;
    cfg_cpha = 1'b0;
    sclk_tick = 1'b1;
    @(negedge clk);
    check("R10 tick ignored idle", sclk, 0);
    sclk_tick = 1'b0;
    xfer_req = 1'b1;
    while (!xfer_grant) @(negedge clk);
    xfer_req = 1'b0;
    sclk_tick = 1'b1;
    @(negedge clk);
    check("R10 lead toggle", sclk, 1);
    check("R11 cpha0 lead strobe", capture, 1);
    @(negedge clk);
    check("R10 trail toggle", sclk, 0);
    check("R11 cpha0 trail quiet", capture, 0);
    cfg_cpha = 1'b1;
    @(negedge clk);
    check("R11 cpha1 lead quiet", capture, 0);
    @(negedge clk);
    check("R11 cpha1 trail strobe", capture, 1);
    sclk_tick = 1'b0;
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    sclk_tick = 1'b1;
    @(negedge clk);
    check("R10 tick ignored hold", sclk, 0);
    check("R11 no strobe hold", capture, 0);
    sclk_tick = 1'b0;
    while (!bus_idle) @(negedge clk);
    check("R9 idle after", cs_n, 4'hF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule